// File: doc/BRIEF.md
# Two-Vector Element Splice Unit

This unit builds one vector of `NUM_ELEM` elements, each `ELEM_W` bits wide, from two input vectors of the same size, a high vector and a low vector. A scalar count picks how many elements come from each side. The unit treats each input as a flat one-dimensional row of elements. Element 0 is the least significant slice, bits `[ELEM_W-1:0]`.

There are two mirrored variants, chosen by `lo_mode`:
- **Splice** (`lo_mode = 0`): the bottom part of the high vector is placed at the top of the result. The top part of the low vector fills the rest.
- **Low-splice** (`lo_mode = 1`): the top of the low vector is placed at the bottom of the result. The bottom of the high vector fills the rest.

The count is first reduced modulo `NUM_ELEM`. Typical uses are:
- building overlapping windows for stencils and convolutions, such as a neighbour element pulled in from the previous or next vector;
- topping off a partial vector with zeros, by tying one input to zero.

Both variants use the same datapath. The two vectors are joined into a `2*NUM_ELEM` element word with high above low. The window is then shifted down by an element count through a barrel selector. The result is registered: one input beat produces one output beat a cycle later, and the unit accepts a new beat every cycle. `NUM_ELEM` must be a power of two.

Top module: `elem_splice_unit`

## Requirements
- R1: In splice mode (`lo_mode = 0`), with m = count mod `NUM_ELEM`, the output element i is:
  - `vec_lo` element i+m for i < `NUM_ELEM`-m;
  - `vec_hi` element i-(`NUM_ELEM`-m) otherwise.
- R2: In low-splice mode (`lo_mode = 1`), the output element i is:
  - `vec_lo` element `NUM_ELEM`-m+i for i < m;
  - `vec_hi` element i-m otherwise.
- R3: A count of `NUM_ELEM` or larger gives exactly the result of count mod `NUM_ELEM`.
- R4: When m = 0:
  - splice mode outputs `vec_lo` unchanged;
  - low-splice mode outputs `vec_hi` unchanged.
- R5: The result for a beat accepted at a rising edge appears on `out_vec` after that edge. Beats on consecutive cycles give results on consecutive cycles.
- R6: `out_valid` equals the value of `in_valid` at the previous rising edge.
- R7: While `in_valid` is low, `out_vec` keeps its last value, whatever `lo_mode`, `count`, `vec_hi` and `vec_lo` carry.
- R8: While `rst_n` is low, `out_valid` is 0 and `out_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| lo_mode | input | 1 | 0 = splice, 1 = low-splice |
| count | input | CNT_W | Element count, reduced modulo NUM_ELEM |
| vec_hi | input | ELEM_W*NUM_ELEM | High input vector |
| vec_lo | input | ELEM_W*NUM_ELEM | Low input vector |
| out_valid | output | 1 | Output beat present |
| out_vec | output | ELEM_W*NUM_ELEM | Spliced result |

## Verification
The bench targets these corner cases, each of which shows a specific design error:
- **Count of zero in each mode.** A design that computes the low-splice shift as `NUM_ELEM - m` without the wrap would emit the wrong half, or zeros, instead of `vec_hi`.
- **Counts of 1 and `NUM_ELEM-1`.** These catch off-by-one errors in the element boundary. A design that swapped the two variants would also fail here, placing the high elements at the wrong end.
- **Counts at and beyond `NUM_ELEM`**, up to the largest count value. These show a design that skipped the modulo reduction and shifted whole vectors out.
- **Idle cycles with changing junk on the inputs.** These expose an output register that loads without a valid beat.

// File: rtl/splice_pkg.sv
package splice_pkg;

    typedef enum logic {
        MODE_SPLICE    = 1'b0,
        MODE_LO_SPLICE = 1'b1
    } splice_mode_e;

endpackage

// File: rtl/splice_shamt.sv
module splice_shamt
    import splice_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int CNT_W    = 8,
    localparam int IDX_W   = $clog2(NUM_ELEM),
    localparam int SH_W    = IDX_W + 1
) (
    input  splice_mode_e     mode,
    input  logic [CNT_W-1:0] count,
    output logic [SH_W-1:0]  shamt
);

    localparam logic [CNT_W-1:0] N_CNT = CNT_W'(NUM_ELEM);
    localparam logic [SH_W-1:0]  N_SH  = SH_W'(NUM_ELEM);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx = IDX_W'(count % N_CNT);
        if (mode == MODE_SPLICE) begin
            shamt = {1'b0, idx};
        end else begin
            shamt = N_SH - {1'b0, idx};
        end
    end

    // R3: the window offset never exceeds one full vector
    always_comb begin
        if (!$isunknown(count) && !$isunknown(mode)) begin
            assert_shamt_range_R3: assert (shamt <= N_SH)
                else $error("shift amount beyond one vector");
        end
    end

endmodule

// File: rtl/splice_barrel.sv
module splice_barrel #(
    parameter int ELEM_W   = 8,
    parameter int NUM_ELEM = 8,
    localparam int IDX_W   = $clog2(NUM_ELEM),
    localparam int SH_W    = IDX_W + 1,
    localparam int VEC_W   = ELEM_W * NUM_ELEM,
    localparam int CAT_W   = 2 * VEC_W
) (
    input  logic [CAT_W-1:0] cat,
    input  logic [SH_W-1:0]  shamt,
    output logic [VEC_W-1:0] win
);

    if ((1 << IDX_W) != NUM_ELEM) begin : g_bad_size
        $error("NUM_ELEM must be a power of two");
    end

    logic [CAT_W-1:0] lvl [0:IDX_W];

    assign lvl[0] = cat;

    for (genvar k = 0; k < IDX_W; k++) begin : g_stage
        assign lvl[k+1] = shamt[k] ? (lvl[k] >> (ELEM_W * (1 << k))) : lvl[k];
    end

    // last stage: a shift by a full vector is a choice of halves
    assign win = shamt[IDX_W] ? lvl[IDX_W][CAT_W-1:VEC_W] : lvl[IDX_W][VEC_W-1:0];

    // R4: a zero offset passes the lower half straight through
    always_comb begin
        if (!$isunknown(shamt) && !$isunknown(cat) && shamt == '0) begin
            assert_pass_through_R4: assert (win == cat[VEC_W-1:0])
                else $error("zero offset changed the window");
        end
    end

endmodule

// File: rtl/elem_splice_unit.sv
module elem_splice_unit
    import splice_pkg::*;
#(
    parameter int ELEM_W   = 8,
    parameter int NUM_ELEM = 8,
    parameter int CNT_W    = 8,
    localparam int IDX_W   = $clog2(NUM_ELEM),
    localparam int SH_W    = IDX_W + 1,
    localparam int VEC_W   = ELEM_W * NUM_ELEM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             lo_mode,
    input  logic [CNT_W-1:0] count,
    input  logic [VEC_W-1:0] vec_hi,
    input  logic [VEC_W-1:0] vec_lo,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec
);

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] data;
    } out_reg_t;

    splice_mode_e     mode;
    logic [SH_W-1:0]  shamt;
    logic [VEC_W-1:0] window;
    out_reg_t         st_d, st_q;

    assign mode = splice_mode_e'(lo_mode);

    splice_shamt #(
        .NUM_ELEM (NUM_ELEM),
        .CNT_W    (CNT_W)
    ) i_shamt (
        .mode  (mode),
        .count (count),
        .shamt (shamt)
    );

    splice_barrel #(
        .ELEM_W   (ELEM_W),
        .NUM_ELEM (NUM_ELEM)
    ) i_barrel (
        .cat   ({vec_hi, vec_lo}),
        .shamt (shamt),
        .win   (window)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.data = window;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_vec   = st_q.data;

    localparam logic [CNT_W-1:0] N_CNT = CNT_W'(NUM_ELEM);

    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("out_valid missing after input beat");

    assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid)
        else $error("out_valid without input beat");

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec))
        else $error("out_vec changed while idle");

    assert_zero_splice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lo_mode && (count % N_CNT) == '0) |=> (out_vec == $past(vec_lo)))
        else $error("splice with zero count did not return low vector");

    assert_zero_lsplice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lo_mode && (count % N_CNT) == '0) |=> (out_vec == $past(vec_hi)))
        else $error("low-splice with zero count did not return high vector");

endmodule

// File: tb/test_elem_splice_unit.sv
module test_elem_splice_unit;

    localparam int W  = 8;
    localparam int N  = 8;
    localparam int CW = 8;
    localparam int VW = W * N;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          lo_mode;
    logic [CW-1:0] count;
    logic [VW-1:0] vec_hi;
    logic [VW-1:0] vec_lo;
    logic          out_valid;
    logic [VW-1:0] out_vec;

    always #4 clk = ~clk;

    elem_splice_unit #(
        .ELEM_W   (W),
        .NUM_ELEM (N),
        .CNT_W    (CW)
    ) i_elem_splice_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .lo_mode   (lo_mode),
        .count     (count),
        .vec_hi    (vec_hi),
        .vec_lo    (vec_lo),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    typedef struct {
        logic          v;
        logic [VW-1:0] d;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            checks = 0;
    int            fails  = 0;
    logic [VW-1:0] last_d = '0;

    function automatic logic [VW-1:0] model(bit lo, int unsigned cnt,
                                            logic [VW-1:0] h, logic [VW-1:0] l);
        logic [VW-1:0] r;
        int m;
        m = int'(cnt % N);
        for (int i = 0; i < N; i++) begin
            if (!lo) begin
                if (i < N - m) r[i*W +: W] = l[(i+m)*W +: W];
                else           r[i*W +: W] = h[(i-(N-m))*W +: W];
            end else begin
                if (i < m)     r[i*W +: W] = l[(N-m+i)*W +: W];
                else           r[i*W +: W] = h[(i-m)*W +: W];
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(bit lo, int unsigned cnt, logic [VW-1:0] h,
                        logic [VW-1:0] l, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        lo_mode  = lo;
        count    = CW'(cnt);
        vec_hi   = h;
        vec_lo   = l;
        e.v   = 1'b1;
        e.d   = model(lo, cnt, h, l);
        e.tag = tag;
        last_d = e.d;
        sb.push_back(e);
    endtask

    task automatic idle(int cycles, string tag);
        exp_t e;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            lo_mode  = 1'($urandom);
            count    = CW'($urandom);
            vec_hi   = {$urandom, $urandom};
            vec_lo   = {$urandom, $urandom};
            e.v   = 1'b0;
            e.d   = last_d;
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    // monitor: pops one expectation per clock once the driver has queued it
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check({"R6 valid, ", e.tag}, {{(VW-1){1'b0}}, out_valid}, {{(VW-1){1'b0}}, e.v});
                check(e.tag, out_vec, e.d);
            end
        end
    end

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [VW-1:0] ph, pl;

    initial begin
        ph = 64'hA7A6A5A4A3A2A1A0;
        pl = 64'h1716151413121110;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        lo_mode  = 1'b0;
        count    = '0;
        vec_hi   = '0;
        vec_lo   = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset valid", {{(VW-1){1'b0}}, out_valid}, '0);
        check("R8 reset data", out_vec, '0);
        @(negedge clk);
        rst_n = 1'b1;

        send(1'b0, 0, ph, pl, "R4 splice zero");
        send(1'b0, 1, ph, pl, "R1 splice n=1");
        send(1'b0, 3, ph, pl, "R1 splice n=3");
        send(1'b0, 7, ph, pl, "R1 splice n=7");
        send(1'b1, 0, ph, pl, "R4 lsplice zero");
        send(1'b1, 1, ph, pl, "R2 lsplice n=1");
        send(1'b1, 5, ph, pl, "R2 lsplice n=5");
        send(1'b1, 7, ph, pl, "R2 lsplice n=7");
        idle(3, "R7 hold after lsplice");
        send(1'b0, 8, ph, pl, "R3 splice n=8");
        send(1'b1, 8, ph, pl, "R3 lsplice n=8");
        send(1'b0, 11, ph, pl, "R3 splice n=11");
        send(1'b1, 13, ph, pl, "R3 lsplice n=13");
        send(1'b0, 255, ph, pl, "R3 splice n=255");
        send(1'b1, 255, ph, pl, "R3 lsplice n=255");
        idle(2, "R7 hold after wrap");
        send(1'b1, 2, '0, pl, "R2 zero pad");
        send(1'b0, 1, 64'h0, pl, "R1 zero top");
        idle(1, "R7 single idle");
        for (int k = 0; k < 60; k++) begin
            send(1'($urandom), $urandom % 256, {$urandom, $urandom},
                 {$urandom, $urandom}, "R5 back-to-back");
            if (k % 9 == 8) idle(1, "R7 gap");
        end
        idle(2, "R7 final hold");

        wait (sb.size() == 0);
        @(posedge clk);
        #3;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule